// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

A general-purpose timer peripheral for a small microcontroller subsystem. The system clock is first thinned by a divide-by-12 enable, which steps a 7-bit down-counting prescaler. A 3-bit ratio select picks one of eight decrement sources for an 8-bit down counter. Ratio 0 uses every prescaler step. Ratio k uses the 1-to-0 transition of prescaler bit k-1. The counter's division ratio is therefore 2 to the power of the select value.

When the counter is decremented to zero, a sticky zero flag is raised. If the interrupt enable is on, an interrupt request follows. Software can also force the flag, either by writing 00h to the counter or by writing 1 to the flag bit. Only a software write clears the flag.

The block is programmed through a byte-wide register port. The port has an address, a write strobe and a read strobe. Read data is combinational.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset the counter reads FFh, the prescaler reads 7Fh, the control register reads 00h and `irq` is low.
- R2: Register map: address 0 is the counter, address 1 is control and address 2 is the prescaler (bit 7 reads 0). Address 3 reads 00h. The control bits are: bit 7 zero flag, bit 6 interrupt enable, bit 3 run, bits 2:0 ratio select. Bits 5:4 read 0. `rd_data` is 00h whenever `rd_en` is low.
- R3: While the run bit is 0, neither the prescaler nor the counter changes unless written, and the divide-by-12 phase is held cleared.
- R4: With run at 1, the prescaler decrements once every 12 clocks and wraps from 00h to 7Fh. The first decrement happens on the 12th rising edge after the edge that wrote run to 1.
- R5: With ratio select 0, the counter decrements on every prescaler step. With ratio select k (1..7), it decrements on a step where prescaler bit k-1 changes from 1 to 0.
- R6: A decrement of the counter from 00h gives FFh, and counting continues.
- R7: A decrement that brings the counter to 00h sets the zero flag.
- R8: The flag is set when software writes 00h to the counter. A control write sets the flag to the value of data bit 7. Hardware never clears the flag.
- R9: `irq` is high exactly while both the zero flag and the interrupt enable are 1.
- R10: A software write to the counter takes priority over a decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, combinational |
| irq | output | 1 | Interrupt request (level) |

## Verification
A wrong prescaler phase or stage selection shows up as a counter value that is off by at least one. It can be read at the counter address within one decrement period of the chosen ratio, which is at most 1536 clocks. A flag fault (missed set, wrong clear) is visible as soon as the cycle after the event, both in control bit 7 and on `irq` when the enable is set. A divider that is not cleared while stopped moves the first prescaler step away from the 12th edge. The next read of the prescaler exposes it.

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer #(
  parameter int DIV   = 12,
  parameter int PRE_W = 7,
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int DIV_W = $clog2(DIV);
  localparam int SEL_W = $clog2(PRE_W + 1);
  localparam logic [1:0] A_CNT = 2'd0, A_CTL = 2'd1, A_PRE = 2'd2;

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q, pre_nx;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             flag_q, ie_q, run_q;
  logic [PRE_W:0]   stage;

  wire wr_cnt = wr_en && (addr == A_CNT);
  wire wr_ctl = wr_en && (addr == A_CTL);
  wire wr_pre = wr_en && (addr == A_PRE);
  wire unused_wr = ^wr_data;

  wire tick = run_q && (div_q == DIV_W'(DIV - 1));
  assign pre_nx = pre_q - 1'b1;

  assign stage[0] = 1'b1;
  for (genvar k = 1; k <= PRE_W; k++) begin : g_stage
    assign stage[k] = pre_q[k-1] & ~pre_nx[k-1];
  end

  // a prescaler write replaces that cycle's step entirely
  wire step     = tick && !wr_pre;
  wire dec      = step && stage[sel_q];
  wire hit_zero = dec && !wr_cnt && (cnt_q == CNT_W'(1));
  wire sw_zero  = wr_cnt && (wr_data[CNT_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_q || tick) div_q <= '0;
    else                          div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '1;
    else if (wr_pre) pre_q <= wr_data[PRE_W-1:0];
    else if (step)   pre_q <= pre_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '1;
    else if (wr_cnt) cnt_q <= wr_data[CNT_W-1:0];
    else if (dec)    cnt_q <= cnt_q - 1'b1;
  end

  // a hardware set wins over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      run_q  <= 1'b0;
      sel_q  <= '0;
    end else begin
      if (hit_zero || sw_zero) flag_q <= 1'b1;
      else if (wr_ctl)         flag_q <= wr_data[7];
      if (wr_ctl) begin
        ie_q  <= wr_data[6];
        run_q <= wr_data[3];
        sel_q <= wr_data[SEL_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr)
        A_CNT:   rd_data = 8'(cnt_q);
        A_CTL:   rd_data = {flag_q, ie_q, 2'b00, run_q, 3'(sel_q)};
        A_PRE:   rd_data = 8'(pre_q);
        default: rd_data = '0;
      endcase
    end
  end

  assign irq = flag_q & ie_q;
endmodule

module prescaled_down_timer_chk #(
  parameter int PRE_W = 7,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             irq,
  input logic [PRE_W-1:0] pre_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flag_q,
  input logic             ie_q,
  input logic             run_q
);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wr_en && addr == 2'd1));

  assert_zero_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == 2'd0 && wr_data == 8'h00) |-> flag_q);

  assert_zero_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && $past(cnt_q) == CNT_W'(1)) |-> flag_q);

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag_q && ie_q && !(wr_en && addr == 2'd1)) |-> irq);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_q && !wr_en) |-> ($stable(cnt_q) && $stable(pre_q)));

  assert_pre_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pre_q) && !$past(wr_en && addr == 2'd2)) |-> pre_q == PRE_W'($past(pre_q) - 1'b1));
endmodule

bind prescaled_down_timer prescaled_down_timer_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .irq(irq),
  .pre_q(pre_q), .cnt_q(cnt_q), .flag_q(flag_q), .ie_q(ie_q), .run_q(run_q)
);

// File: tb/prescaled_down_timer_tb.sv
`timescale 1ns/1ps
module prescaled_down_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prescaled_down_timer dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic en, output logic [7:0] d);
    addr = a; rd_en = en; #1 d = rd_data; rd_en = 1'b0;
  endtask

  // returns {flag, prescaler, counter} after a number of prescaler steps
  function automatic logic [15:0] model(input logic [6:0] p, input logic [7:0] c,
                                        input int s, input int steps);
    logic f = 1'b0;
    for (int t = 0; t < steps; t++) begin
      logic [6:0] po = p;
      logic dec;
      p = p - 7'd1;
      dec = (s == 0) ? 1'b1 : (po[s-1] & ~p[s-1]);
      if (dec) begin
        c = c - 8'd1;
        if (c == 8'h00) f = 1'b1;
      end
    end
    return {f, p, c};
  endfunction

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    rd(2'd0, 1'b1, v); check("R1 counter reset", v, 8'hFF);
    rd(2'd1, 1'b1, v); check("R1 control reset", v, 8'h00);
    rd(2'd2, 1'b1, v); check("R1 prescaler reset", v, 8'h7F);
    check("R1 irq reset", {7'd0, irq}, 8'h00);
    rd(2'd3, 1'b1, v); check("R2 unused address", v, 8'h00);
    rd(2'd0, 1'b0, v); check("R2 read strobe low", v, 8'h00);

    wr(2'd1, 8'hF7);
    rd(2'd1, 1'b1, v); check("R2 reserved bits / R8 flag by bit7", v, 8'hC7);
    check("R9 irq with flag and enable", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h40);
    rd(2'd1, 1'b1, v); check("R8 flag cleared by write", v, 8'h40);
    check("R9 irq low after clear", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd1, 1'b1, v); check("R8 flag by counter 00h write", v, 8'hC0);
    check("R9 irq after counter zero write", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h80);
    check("R9 irq masked when enable off", {7'd0, irq}, 8'h00);

    repeat (100) @(posedge clk); #2;
    rd(2'd0, 1'b1, v); check("R3 counter held while stopped", v, 8'h00);
    rd(2'd2, 1'b1, v); check("R3 prescaler held while stopped", v, 8'h7F);

    wr(2'd1, 8'h00); wr(2'd2, 8'h7F); wr(2'd0, 8'h05);
    wr(2'd1, 8'h08);
    repeat (10) @(posedge clk); #2;
    rd(2'd2, 1'b1, v); check("R4 no step before 12th edge", v, 8'h7F);
    @(posedge clk); #1;
    wr(2'd0, 8'h40);
    rd(2'd0, 1'b1, v); check("R10 write beats decrement", v, 8'h40);
    rd(2'd2, 1'b1, v); check("R4 step on 12th edge", v, 8'h7E);

    wr(2'd1, 8'h00); wr(2'd2, 8'h7F); wr(2'd0, 8'h01);
    wr(2'd1, 8'h48);
    repeat (12) @(posedge clk); #2;
    rd(2'd0, 1'b1, v); check("R7 counter reaches zero", v, 8'h00);
    rd(2'd1, 1'b1, v); check("R7 flag on reaching zero", v, 8'hC8);
    check("R9 irq on zero", {7'd0, irq}, 8'h01);
    repeat (12) @(posedge clk); #2;
    rd(2'd0, 1'b1, v); check("R6 counter wraps to FFh", v, 8'hFF);
    rd(2'd1, 1'b1, v); check("R8 flag stays set", v, 8'hC8);

    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h10);
    wr(2'd1, 8'h08);
    repeat (12) @(posedge clk); #2;
    rd(2'd2, 1'b1, v); check("R4 prescaler wraps to 7Fh", v, 8'h7F);

    for (int i = 0; i < 32; i++) begin
      int s = i % 8;
      logic ie = 1'($urandom % 2);
      logic [6:0] p = 7'($urandom % 128);
      logic [7:0] c = 8'(1 + $urandom % 6);
      int n = 1 + int'($urandom % 2500);
      logic [15:0] e;
      wr(2'd1, {1'b0, ie, 2'b00, 1'b0, 3'(s)});
      wr(2'd2, {1'b0, p});
      wr(2'd0, c);
      wr(2'd1, {1'b0, ie, 2'b00, 1'b1, 3'(s)});
      repeat (n) @(posedge clk); #2;
      e = model(p, c, s, n / 12);
      rd(2'd0, 1'b1, v); check($sformatf("R5 counter sel=%0d", s), v, e[7:0]);
      rd(2'd2, 1'b1, v); check($sformatf("R4 prescaler sel=%0d", s), v, {1'b0, e[14:8]});
      rd(2'd1, 1'b1, v); check($sformatf("R7 flag sel=%0d", s), v, {e[15], ie, 2'b00, 1'b1, 3'(s)});
      check($sformatf("R9 irq sel=%0d", s), {7'd0, irq}, {7'd0, e[15] & ie});
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule